// File: doc/BRIEF.md
# Non-Overlapping Bridge Excitation Driver

This block produces two complementary control lines that decide the polarity of the excitation applied to a resistive bridge. A high level on the true line means the bridge is excited with normal polarity. A high level on the complement line means the excitation is reversed. The block runs on the master clock. When both the AC-mode enable and the chop-mode enable are set, it swaps the polarity after a programmable number of master clock cycles. Between the two drive states it always inserts a single cycle in which neither line is high.

When either enable is low, the block parks with the true line high and the complement line low. If the enables are removed while the reversed phase is active, the block first passes through one dead cycle and then parks. A phase flag tells downstream logic which polarity was most recently driven, and the flag keeps that value through the dead cycle that follows. An active-low synchronous reset returns the block to the parked state.

Top module: `bridge_exc_driver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `exc_pos`=1, `exc_neg`=0 and `phase_rev`=0.
- R2: While `ac_en` or `chop_en` is low and the block is parked, `exc_pos` stays 1 and `exc_neg` stays 0. Each enable alone is enough to keep the block parked.
- R3: `exc_pos` and `exc_neg` are never high in the same cycle.
- R4: Every change of drive polarity passes through exactly one master clock cycle in which `exc_pos` and `exc_neg` are both 0.
- R5: With both enables high, each drive phase (true high, or complement high) lasts `half_period` master clock cycles. A `half_period` of 0 behaves as 1.
- R6: With both enables high, the sequence is: normal phase, dead cycle, reversed phase, dead cycle, normal phase, and so on. `exc_neg` rises only right after a dead cycle.
- R7: Taking an enable away during the reversed phase gives one dead cycle and then the parked levels. Taking it away during a dead cycle ends that dead cycle and then parks. No drive pulse appears in either case.
- R8: `phase_rev` is 1 during the reversed phase and during the dead cycle that follows it. It is 0 during the normal phase and during the dead cycle that follows that phase.
- R9: When the enables are raised on a parked block, the normal phase continues for `half_period`-1 more cycles (counted from the first edge at which the enables are sampled), and then the first dead cycle follows.

Ports are listed in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ac_en | input | 1 | AC excitation mode enable |
| chop_en | input | 1 | Chop mode enable |
| half_period | input | PER_W | Length of one drive phase in master clock cycles (0 acts as 1) |
| exc_pos | output | 1 | True excitation control, high for normal polarity |
| exc_neg | output | 1 | Complement excitation control, high for reversed polarity |
| phase_rev | output | 1 | Most recently driven polarity is reversed |

## Verification
The hardest cases are the enable being removed at one exact phase point: during the reversed phase, or in the single dead cycle just before the reversed phase starts. Only those two points show whether the park path inserts its dead cycle or suppresses a pending drive pulse. The bench gets there by computing, from the requirements, the sample index at which each phase begins. It then withdraws the enable at the negative edge right after the target state is observed and compares every following sample with the expected park sequence. Zero and one half-periods are also run, because there the dead cycles pack between single-cycle drive phases.

// File: rtl/exc_drv_pkg.sv
// Shared definitions for the bridge excitation driver.
// Phase encoding: the two gap states record which drive phase comes next.
package exc_drv_pkg;

    typedef enum logic [1:0] {
        PH_NORM        = 2'd0,  // true line driven
        PH_GAP_TO_REV  = 2'd1,  // dead cycle after normal phase
        PH_REV         = 2'd2,  // complement line driven
        PH_GAP_TO_NORM = 2'd3   // dead cycle after reversed phase
    } exc_phase_t;

endpackage

// File: rtl/exc_phase_timer.sv
// Counts master clock cycles within one drive phase.
// Assumes: run is high only while a drive phase is active and enabled;
// a half period of zero is treated as one cycle.
module exc_phase_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] half_period,
    output logic             expire
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] last_idx;

    // Index of the final cycle of a phase, clamped for a zero period.
    always_comb begin
        last_idx = (half_period == '0) ? '0 : half_period - ONE;
        expire   = run && (cnt >= last_idx);
    end

    // Cycle counter, cleared when idle or at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/exc_phase_fsm.sv
// Phase sequencer: normal -> gap -> reversed -> gap -> normal.
// Assumes expire is only asserted while run is high. Disabling in a
// reversed phase goes through a gap; disabling in a gap lands in normal.
module exc_phase_fsm
    import exc_drv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       expire,
    output logic       run,
    output exc_phase_t phase_nxt
);
    exc_phase_t phase_q;

    // Timer runs only in a drive phase while enabled.
    always_comb begin
        run = enable && ((phase_q == PH_NORM) || (phase_q == PH_REV));
    end

    // Next-phase selection.
    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_NORM:        if (enable && expire) phase_nxt = PH_GAP_TO_REV;
            PH_GAP_TO_REV:  phase_nxt = enable ? PH_REV : PH_NORM;
            PH_REV:         if (!enable || expire) phase_nxt = PH_GAP_TO_NORM;
            PH_GAP_TO_NORM: phase_nxt = PH_NORM;
            default:        phase_nxt = PH_NORM;
        endcase
    end

    // Phase register, parked in normal polarity at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_NORM;
        end else begin
            phase_q <= phase_nxt;
        end
    end
endmodule

// File: rtl/exc_out_stage.sv
// Registered output decode so the pins come straight from flops.
// Assumes the incoming phase is the sequencer's next phase, keeping the
// pins aligned with the sequencer state.
module exc_out_stage
    import exc_drv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  exc_phase_t phase_nxt,
    output logic       exc_pos,
    output logic       exc_neg,
    output logic       phase_rev
);
    // Output flops: true line high only in normal, complement only in reversed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_pos   <= 1'b1;
            exc_neg   <= 1'b0;
            phase_rev <= 1'b0;
        end else begin
            exc_pos   <= (phase_nxt == PH_NORM);
            exc_neg   <= (phase_nxt == PH_REV);
            phase_rev <= (phase_nxt == PH_REV) || (phase_nxt == PH_GAP_TO_NORM);
        end
    end
endmodule

// File: rtl/bridge_exc_driver.sv
// Top: complementary bridge excitation control with one-cycle dead time.
// Assumes all inputs are synchronous to clk.
module bridge_exc_driver
    import exc_drv_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ac_en,
    input  logic             chop_en,
    input  logic [PER_W-1:0] half_period,
    output logic             exc_pos,
    output logic             exc_neg,
    output logic             phase_rev
);
    logic       enable;
    logic       run;
    logic       expire;
    exc_phase_t phase_nxt;

    // Toggling needs both modes on.
    always_comb begin
        enable = ac_en && chop_en;
    end

    exc_phase_timer #(.PER_W(PER_W)) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .half_period (half_period),
        .expire      (expire)
    );

    exc_phase_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .expire    (expire),
        .run       (run),
        .phase_nxt (phase_nxt)
    );

    exc_out_stage i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_nxt (phase_nxt),
        .exc_pos   (exc_pos),
        .exc_neg   (exc_neg),
        .phase_rev (phase_rev)
    );
endmodule

// File: rtl/exc_drv_checker.sv
// Port-level properties of the excitation driver, bound to the top.
module exc_drv_checker (
    input logic clk,
    input logic rst_n,
    input logic ac_en,
    input logic chop_en,
    input logic exc_pos,
    input logic exc_neg,
    input logic phase_rev
);
    logic gap;
    always_comb gap = !exc_pos && !exc_neg;

    assert_reset_park_R1: assert property (@(posedge clk)
        !rst_n |=> (exc_pos && !exc_neg && !phase_rev));

    assert_park_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ac_en && chop_en) && exc_pos) |=> (exc_pos && !exc_neg));

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_pos && exc_neg));

    assert_gap_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gap |=> (exc_pos || exc_neg));

    assert_fall_to_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exc_pos) |-> !exc_neg);

    assert_rev_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_neg) |-> $past(gap));

    assert_drop_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ac_en && chop_en) && exc_neg) |=> gap);

    assert_gap_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ac_en && chop_en) && gap) |=> (exc_pos && !exc_neg));

    assert_flag_rev_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_neg |-> phase_rev);

    assert_flag_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pos |-> !phase_rev);
endmodule

bind bridge_exc_driver exc_drv_checker i_exc_drv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ac_en     (ac_en),
    .chop_en   (chop_en),
    .exc_pos   (exc_pos),
    .exc_neg   (exc_neg),
    .phase_rev (phase_rev)
);

// File: tb/test_bridge_exc_driver.sv
// Directed bench: one task per scenario, each checking its own samples.
module test_bridge_exc_driver;
    localparam int PER_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ac_en = 1'b0;
    logic             chop_en = 1'b0;
    logic [PER_W-1:0] half_period = '0;
    logic             exc_pos;
    logic             exc_neg;
    logic             phase_rev;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    bridge_exc_driver #(.PER_W(PER_W)) i_bridge_exc_driver (
        .clk         (clk),
        .rst_n       (rst_n),
        .ac_en       (ac_en),
        .chop_en     (chop_en),
        .half_period (half_period),
        .exc_pos     (exc_pos),
        .exc_neg     (exc_neg),
        .phase_rev   (phase_rev)
    );

    always #10 clk = ~clk;

    task automatic check_outs(input logic ep, input logic en, input logic er, input string req);
        n_checks++;
        if (exc_pos !== ep || exc_neg !== en || phase_rev !== er) begin
            n_fails++;
            $display("FAIL %s: pos/neg/rev got %b%b%b expected %b%b%b at %0t",
                     req, exc_pos, exc_neg, phase_rev, ep, en, er, $time);
        end
    endtask

    // Advance one edge and sample shortly after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected code of sample k (k>=1) after enabling a parked block.
    // 0 normal, 1 gap after normal, 2 reversed, 3 gap after reversed.
    function automatic int exp_code(input int k, input int hp);
        int he = (hp < 1) ? 1 : hp;
        int j, m;
        if (k <= he - 1) return 0;
        j = k - he;
        m = j % (2 * he + 2);
        if (m == 0) return 1;
        if (m <= he) return 2;
        if (m == he + 1) return 3;
        return 0;
    endfunction

    task automatic check_code(input int c, input string req);
        check_outs(c == 0, c == 2, c >= 2, req);
    endtask

    // Remove enables and wait until surely parked.
    task automatic go_park();
        @(negedge clk);
        ac_en = 1'b0;
        chop_en = 1'b0;
        repeat (4) step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) step();
        check_outs(1'b1, 1'b0, 1'b0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check_outs(1'b1, 1'b0, 1'b0, "R1 after release");
    endtask

    task automatic t_park_single_enable();
        @(negedge clk);
        half_period = 16'd2;
        ac_en = 1'b1;
        chop_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step();
            check_outs(1'b1, 1'b0, 1'b0, "R2 ac only");
        end
        @(negedge clk);
        ac_en = 1'b0;
        chop_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            check_outs(1'b1, 1'b0, 1'b0, "R2 chop only");
        end
        go_park();
    endtask

    // R5, R6, R9, R3, R4, R8: full toggling sequence for one period.
    task automatic t_toggle(input int hp);
        int he = (hp < 1) ? 1 : hp;
        @(negedge clk);
        half_period = PER_W'(hp);
        ac_en = 1'b1;
        chop_en = 1'b1;
        for (int k = 1; k <= (he - 1) + 3 * (2 * he + 2); k++) begin
            step();
            check_code(exp_code(k, hp), "R5 R6 R9 toggle sequence");
        end
        go_park();
    endtask

    // R7: enable dropped in the reversed phase.
    task automatic t_drop_in_rev();
        @(negedge clk);
        half_period = 16'd3;
        ac_en = 1'b1;
        chop_en = 1'b1;
        for (int k = 1; k <= 4; k++) step();
        check_code(2, "R7 reached reversed phase");
        @(negedge clk);
        chop_en = 1'b0;
        step();
        check_code(3, "R7 dead cycle before park");
        for (int i = 0; i < 6; i++) begin
            step();
            check_code(0, "R7 parked after reversed");
        end
        go_park();
    endtask

    // R7: enable dropped in the gap ahead of the reversed phase.
    task automatic t_drop_in_gap();
        @(negedge clk);
        half_period = 16'd3;
        ac_en = 1'b1;
        chop_en = 1'b1;
        for (int k = 1; k <= 3; k++) step();
        check_code(1, "R7 reached gap");
        @(negedge clk);
        ac_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            check_code(0, "R7 parked from gap, no reversed pulse");
        end
        go_park();
    endtask

    // R1: reset while in the reversed phase.
    task automatic t_reset_midrun();
        @(negedge clk);
        half_period = 16'd3;
        ac_en = 1'b1;
        chop_en = 1'b1;
        for (int k = 1; k <= 5; k++) step();
        check_code(2, "R1 pre-reset reversed");
        @(negedge clk);
        rst_n = 1'b0;
        ac_en = 1'b0;
        chop_en = 1'b0;
        step();
        check_outs(1'b1, 1'b0, 1'b0, "R1 reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) step();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_park_single_enable();
        t_toggle(3);
        t_toggle(1);
        t_toggle(0);
        t_toggle(5);
        t_drop_in_rev();
        t_drop_in_gap();
        t_reset_midrun();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule